// File: doc/BRIEF.md
# Receiver Active Failsafe Controller

This block is the digital decision stage behind a differential bus receiver. Two comparator flags arrive from the analog front end. One says the bus sits clearly above the positive threshold (+200 mV), the other says it sits clearly below the negative threshold (−200 mV). When neither flag is set, the bus is in the undefined band between them. The block resynchronises both flags, drives the received data bit while the bus is valid, and runs a watchdog timer on the undefined band. If the bus stays undefined long enough, as with an open, shorted or idle terminated line, the timer trips and the data bit goes high. Noise on a dead line therefore never appears as data.

Two enables come in with the flags: an active-high receiver-off input and an active-high driver-enable input. The receiver-off input controls the tristate enable of the data pin. When the driver is off and the receiver is off at the same time, the block enters a low-power standby. In standby the timer is parked at zero and the data state is reset to high. On leaving standby, a short settling window keeps the output at a defined high level. Normal decisions resume after that window. The timeout and the settling window are parameters given in clock cycles. At 100 MHz the defaults are 25000 cycles (250 µs) and 800 cycles (8 µs).

Top module: `rx_failsafe_ctrl`

## Requirements
- R1: Each comparator flag passes through two synchronizing flops. A change on the raw flags shows on `rx_data` at the third rising clock edge after the change.
- R2: A synchronized sample with `bus_hi_raw`=1 and `bus_lo_raw`=0 makes `rx_data` 1 at the next edge. A sample with `bus_hi_raw`=0 and `bus_lo_raw`=1 makes it 0.
- R3: A sample with both flags 0 or both flags 1 is invalid. It never drives `rx_data` low and it advances the failsafe timer.
- R4: `rx_data` keeps its last value through the first TIMEOUT_CYC−1 consecutive invalid samples. It goes high at the edge that processes the TIMEOUT_CYC-th sample and stays high while the bus stays invalid.
- R5: Any valid sample clears the timer. A later invalid run needs the full TIMEOUT_CYC samples again before it trips.
- R6: `rx_oe` is the inverse of `rx_off` in the same cycle: 1 drives the data pin, 0 leaves it in high impedance.
- R7: `standby` is 1 in the cycle after an edge that saw `drv_en`=0 and `rx_off`=1. Otherwise it is 0 after that edge.
- R8: While `standby` is 1, the timer is held at zero and `rx_data` is 1 from the following edge on, whatever the bus flags are.
- R9: After `standby` falls, `rx_data` is held at 1 and the timer at zero for WAKE_CYC cycles (WAKE_CYC ≥ 1). After that the bus flags are followed normally.
- R10: During and right after reset, `rx_data` is 1, `standby` is 0 and the timer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_hi_raw | input | 1 | Asynchronous flag: bus validly high |
| bus_lo_raw | input | 1 | Asynchronous flag: bus validly low |
| rx_off | input | 1 | Receiver disable, active high |
| drv_en | input | 1 | Driver enable, active high |
| rx_data | output | 1 | Received data bit |
| rx_oe | output | 1 | Output enable for the tristate data pin |
| standby | output | 1 | Low-power standby is active |

## Verification
Bus flags reach `rx_data` three edges after they change: two synchronizer edges and one decision edge. A timeout appears TIMEOUT_CYC+2 edges after the bus goes undefined. `standby` follows the enables by one edge, while `rx_oe` follows `rx_off` in the same cycle. The bench drives inputs on the falling edge and runs a behavioural model on each rising edge. It compares all three outputs at the next falling edge, so every expected value already includes those latencies. Explicit checks count the edge-by-edge latency of the data path and of the timeout.

// File: rtl/fsafe_pkg.sv
package fsafe_pkg;

    typedef enum logic [1:0] {
        BUS_UNDEF = 2'd0,
        BUS_HIGH  = 2'd1,
        BUS_LOW   = 2'd2
    } bus_state_e;

    // Both flags at once is contradictory and is treated as undefined (R3)
    function automatic bus_state_e classify(input logic hi, input logic lo);
        if (hi && !lo) return BUS_HIGH;
        if (lo && !hi) return BUS_LOW;
        return BUS_UNDEF;
    endfunction

endpackage

// File: rtl/fsafe_sync.sv
module fsafe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/fsafe_power.sv
module fsafe_power #(
    parameter int WAKE_CYC = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic rx_off,
    output logic standby_o,
    output logic hold_o
);

    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE_CYC);

    typedef struct packed {
        logic          st;
        logic [WW-1:0] wk;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    always_comb begin
        pwr_d    = pwr_q;
        pwr_d.st = !drv_en && rx_off;
        if (pwr_q.st)
            pwr_d.wk = WAKE_LOAD;
        else if (pwr_q.wk != '0)
            pwr_d.wk = pwr_q.wk - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= '0;
        else        pwr_q <= pwr_d;
    end

    assign standby_o = pwr_q.st;
    assign hold_o    = pwr_q.st || (pwr_q.wk != '0);

    // R9: the cycle standby drops must still be a held cycle
    p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_q.st) |-> hold_o);

    // R7: standby reflects the enables sampled at the previous edge
    p_standby_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en || !rx_off) |=> !standby_o);

endmodule

// File: rtl/fsafe_timer.sv
module fsafe_timer
    import fsafe_pkg::*;
#(
    parameter int TIMEOUT_CYC = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_state_e bus_st,
    input  logic       hold,
    output logic       data_o
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          dat;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (hold) begin
            tmr_d.cnt = '0;
            tmr_d.dat = 1'b1;
        end else begin
            unique case (bus_st)
                BUS_HIGH: begin
                    tmr_d.cnt = '0;
                    tmr_d.dat = 1'b1;
                end
                BUS_LOW: begin
                    tmr_d.cnt = '0;
                    tmr_d.dat = 1'b0;
                end
                default: begin
                    if (tmr_q.cnt != LIMIT)
                        tmr_d.cnt = tmr_q.cnt + 1'b1;
                    if (tmr_d.cnt == LIMIT)
                        tmr_d.dat = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{cnt: '0, dat: 1'b1};
        else        tmr_q <= tmr_d;
    end

    assign data_o = tmr_q.dat;

    p_follow_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st == BUS_LOW && !hold) |=> !data_o);

    p_follow_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st == BUS_HIGH && !hold) |=> data_o);

    p_only_low_pulls_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_o) |-> $past(bus_st == BUS_LOW));

    p_hold_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (tmr_q.cnt == '0 && data_o));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LIMIT);

    p_valid_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st != BUS_UNDEF) |=> tmr_q.cnt == '0);

endmodule

// File: rtl/rx_failsafe_ctrl.sv
module rx_failsafe_ctrl
    import fsafe_pkg::*;
#(
    parameter int TIMEOUT_CYC = 25000,
    parameter int WAKE_CYC    = 800,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_hi_raw,
    input  logic bus_lo_raw,
    input  logic rx_off,
    input  logic drv_en,
    output logic rx_data,
    output logic rx_oe,
    output logic standby
);

    logic [1:0] flags_s;
    logic       hold;
    bus_state_e bus_st;

    fsafe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_hi_raw, bus_lo_raw}),
        .sync_o  (flags_s)
    );

    assign bus_st = classify(flags_s[1], flags_s[0]);

    fsafe_power #(.WAKE_CYC(WAKE_CYC)) u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_en    (drv_en),
        .rx_off    (rx_off),
        .standby_o (standby),
        .hold_o    (hold)
    );

    fsafe_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_st (bus_st),
        .hold   (hold),
        .data_o (rx_data)
    );

    assign rx_oe = !rx_off;

    // R8: a standby cycle leaves the data bit high at the next edge
    p_standby_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> rx_data);

endmodule

// File: tb/test_rx_failsafe_ctrl.sv
module test_rx_failsafe_ctrl;

    localparam int TMO  = 20;
    localparam int WAKE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_hi_raw = 1'b0, bus_lo_raw = 1'b0, rx_off = 1'b0, drv_en = 1'b1;
    logic rx_data, rx_oe, standby;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    rx_failsafe_ctrl #(.TIMEOUT_CYC(TMO), .WAKE_CYC(WAKE)) i_rx_failsafe_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_hi_raw(bus_hi_raw), .bus_lo_raw(bus_lo_raw),
        .rx_off(rx_off), .drv_en(drv_en), .rx_data(rx_data), .rx_oe(rx_oe),
        .standby(standby)
    );

    // Behavioural reference: flag delay line, invalid-run length, wake countdown
    bit hq[$], lq[$];
    int m_run, m_wake;
    bit m_dat, m_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            hq = '{0, 0}; lq = '{0, 0};
            m_run = 0; m_wake = 0; m_dat = 1; m_st = 0;
        end else begin
            bit h, l, held;
            h = hq.pop_front(); l = lq.pop_front();
            hq.push_back(bus_hi_raw); lq.push_back(bus_lo_raw);
            held = m_st || (m_wake > 0);
            if (held) begin
                m_run = 0; m_dat = 1;
            end else if (h != l) begin
                m_run = 0; m_dat = h;
            end else begin
                if (m_run < TMO) m_run++;
                if (m_run >= TMO) m_dat = 1;
            end
            if (m_st) m_wake = WAKE;
            else if (m_wake > 0) m_wake--;
            m_st = !drv_en && rx_off;
        end
    end

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(rx_data, m_dat, "rx_data");
        chk(rx_oe, !rx_off, "rx_oe");
        chk(standby, m_st, "standby");
    endtask

    task automatic drive(input logic h, input logic l, input int n);
        bus_hi_raw = h; bus_lo_raw = l;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        cur_req = "R10";
        chk(rx_data, 1'b1, "reset data");
        chk(standby, 1'b0, "reset standby");
        rst_n = 1'b1;
        tick();
        chk(rx_data, 1'b1, "after reset data");

        // R2: valid low and valid high patterns
        cur_req = "R2";
        drive(0, 1, 6); chk(rx_data, 1'b0, "valid low");
        drive(1, 0, 6); chk(rx_data, 1'b1, "valid high");
        for (int i = 0; i < 6; i++) drive(i[0], !i[0], 1);
        drive(0, 1, 4);

        // R1: three-edge latency from raw flag to data
        cur_req = "R1";
        drive(1, 0, 4);
        bus_hi_raw = 0; bus_lo_raw = 1;
        tick(); chk(rx_data, 1'b1, "edge 1");
        tick(); chk(rx_data, 1'b1, "edge 2");
        tick(); chk(rx_data, 1'b0, "edge 3");

        // R3: both flags set count as undefined and never pull low
        cur_req = "R3";
        drive(1, 1, 10); chk(rx_data, 1'b0, "both flags before timeout");
        drive(1, 1, 12); chk(rx_data, 1'b1, "both flags tripped");
        drive(0, 1, 4);

        // R4: exact trip edge for an undefined run
        cur_req = "R4";
        bus_hi_raw = 0; bus_lo_raw = 0;
        for (int i = 1; i <= TMO + 2; i++) begin
            tick(); chk(rx_data, (i == TMO + 2), "trip timing");
        end
        drive(0, 0, 8); chk(rx_data, 1'b1, "stays high");

        // R5: a one-sample valid low restarts the count
        cur_req = "R5";
        drive(0, 1, 4);
        drive(0, 0, 15);
        drive(0, 1, 1);
        drive(0, 0, 15); chk(rx_data, 1'b0, "count restarted");
        drive(0, 0, 10); chk(rx_data, 1'b1, "later trip");

        // R6: tristate enable follows rx_off, no standby while driver on
        cur_req = "R6";
        drive(0, 1, 4);
        rx_off = 1; #1; chk(rx_oe, 1'b0, "off");
        drive(0, 1, 3);
        rx_off = 0; #1; chk(rx_oe, 1'b1, "on");
        drive(0, 1, 2);

        // R7 and R8: standby entry with low on the bus
        cur_req = "R7";
        drv_en = 0; rx_off = 1;
        tick(); chk(standby, 1'b1, "entered");
        cur_req = "R8";
        drive(0, 1, 10); chk(rx_data, 1'b1, "forced high in standby");
        drive(0, 0, 30); chk(rx_data, 1'b1, "timer parked");

        // R9: settling window after wake-up
        cur_req = "R9";
        bus_hi_raw = 0; bus_lo_raw = 1;
        rx_off = 0;
        tick(); chk(standby, 1'b0, "left");
        for (int i = 1; i <= WAKE + 2; i++) begin
            tick(); chk(rx_data, (i <= WAKE), "wake window");
        end
        drive(0, 1, 3);
        cur_req = "R7";
        drv_en = 1; rx_off = 1; tick(); chk(standby, 1'b0, "driver on");
        rx_off = 0; drive(1, 0, 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule